// File: doc/BRIEF.md
# PCIe Function Power-Management Controller

This block holds the power-management state of a single PCIe endpoint function. Software reaches it through a 16-bit control/status register (called PMCSR below) behind a plain write strobe and an always-valid read bus. A write to the power-state field does not switch state at once. It starts a countdown, and the new state is reported only when the countdown runs out. Requests that arrive while a countdown runs are queued, and the most recent one is kept.

Internal wake-worthy events always latch a status flag. The controller turns such an event into a one-cycle request toward the message generator only when software has enabled it, the function is powered, and no turn-off handshake has silenced it. When main power is removed from D3hot, the function enters D3cold. In that state an active-low wake pin takes over signalling, provided it was built in and auxiliary power is present. A turn-off request from the link side is always answered with an acknowledge pulse.

Compile-time switches remove the whole PMCSR machinery, remove the wake pin, or replace the auxiliary-power input with a fixed level.

Top module: `pm_func_ctrl`

## Requirements
- R1: After reset the reported state is D0 (encoding 0), the read bus is 0, wake_n_o is 1, and pme_req_o and turnoff_ack_o are 0.
- R2: PMCSR reads as: power state in bits [1:0] (00 D0, 01 D1, 10 D2, 11 D3hot), PME enable in bit 8, PME status in bit 15, every other bit 0. The whole word reads 0 while in D3cold (pwr_state_o encoding 4).
- R3: Writing 1 to bit 15 clears PME status. Writing 0 there leaves it unchanged. Bit 8 takes the written value on every write made outside D3cold.
- R4: An accepted power-state write changes pwr_state_o exactly TRANS_CYC clock edges after the write edge, and not before.
- R5: A power-state write is ignored if it names an unsupported state, names the state already in effect, or asks D3hot for anything other than D0. Writes in D3cold have no effect at all.
- R6: An accepted write made while a countdown runs is held and starts when that countdown completes. A later accepted write replaces the held one.
- R7: A pme_event_i pulse sets PME status regardless of the enable bit. pme_req_o pulses on the next cycle only if the enable bit was set, the function was not in D3cold, and no turn-off was outstanding.
- R8: With main_pwr_off_i high and no countdown running, D3hot moves to D3cold on the next edge. When main_pwr_off_i falls, D3cold returns to D0 on the next edge. Enable and status survive only if auxiliary power is present, and an event in D3cold without auxiliary power is ignored.
- R9: wake_n_o is low only when wake support is built in, the state is D3cold, auxiliary power is present, and both enable and status are set. Otherwise it is high, and with wake support left out it is high at all times.
- R10: turnoff_req_i is answered by a one-cycle turnoff_ack_o on the next cycle. pme_req_o then stays suppressed until a transition into D0 completes or D3cold is left.
- R11: With PME handling not built in, the read bus is 0, the state is D0, pme_req_o is 0 and wake_n_o is 1, while turn-off requests are still acknowledged.
- R12: With the auxiliary-power pin not used, the block uses the built-in level AUX_TIE (default 0, meaning no auxiliary power) and ignores aux_pwr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | PMCSR write strobe |
| cfg_wdata_i | input | 16 | PMCSR write data |
| cfg_rdata_o | output | 16 | PMCSR read data |
| pme_event_i | input | 1 | Internal wake-worthy event pulse |
| main_pwr_off_i | input | 1 | Main power removed (level) |
| aux_pwr_i | input | 1 | Auxiliary power present |
| turnoff_req_i | input | 1 | Turn-off request pulse from the link side |
| turnoff_ack_o | output | 1 | Turn-off acknowledge pulse |
| pme_req_o | output | 1 | PME message request pulse |
| wake_n_o | output | 1 | Wake output, active low |
| pwr_state_o | output | 3 | Current state: 0 D0, 1 D1, 2 D2, 3 D3hot, 4 D3cold |

## Verification
A countdown that is off by one edge shows up on pwr_state_o and on bits [1:0] of the read bus in the very cycle the change lands. A corrupted held request shows up one full countdown later, when an unexpected state is reported. Errors in the enable, status or turn-off flags stay invisible until the next event pulse, which then produces a request or wake level that is wrong on the following cycle. A lost sticky bit after a D3cold exit is visible on the first read after power returns. The bench therefore compares every output to a behavioural model on every clock, and uses event pulses and reads right after each power transition.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    PM_D0     = 3'd0,
    PM_D1     = 3'd1,
    PM_D2     = 3'd2,
    PM_D3HOT  = 3'd3,
    PM_D3COLD = 3'd4
  } pm_state_e;

  localparam int CSR_W   = 16;
  localparam int EN_BIT  = 8;
  localparam int STS_BIT = 15;
  localparam int ST_W    = 2;
endpackage

// File: rtl/pm_dstate_ctrl.sv
module pm_dstate_ctrl
  import pm_pkg::*;
#(
  parameter int TRANS_CYC = 16,
  parameter bit SUP_D1    = 1'b1,
  parameter bit SUP_D2    = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [ST_W-1:0] req_i,
  input  logic            pwr_off_i,
  output pm_state_e       state_o,
  output logic            d0_done_o,
  output logic            cold_exit_o
);
  localparam int CNT_W = (TRANS_CYC < 2) ? 1 : $clog2(TRANS_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRANS_CYC - 1);
  localparam logic [3:0] SUP_MASK = {1'b1, SUP_D2, SUP_D1, 1'b1};

  pm_state_e        cur_q, tgt_q, pend_q;
  logic             busy_q, pv_q;
  logic [CNT_W-1:0] cnt_q;

  pm_state_e eff_st, req_st;
  logic      acc, completing;

  always_comb begin
    req_st     = pm_state_e'({1'b0, req_i});
    eff_st     = pv_q ? pend_q : (busy_q ? tgt_q : cur_q);
    completing = busy_q && (cnt_q == '0);
    acc = wr_i && (cur_q != PM_D3COLD) && (req_st != eff_st) && SUP_MASK[req_i]
          && !((eff_st == PM_D3HOT) && (req_st != PM_D0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= PM_D0;
      tgt_q  <= PM_D0;
      pend_q <= PM_D0;
      busy_q <= 1'b0;
      pv_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (cur_q == PM_D3COLD) begin
      if (!pwr_off_i) cur_q <= PM_D0;
    end else if (busy_q) begin
      if (!completing) begin
        cnt_q <= cnt_q - 1'b1;
        if (acc) begin
          pend_q <= req_st;
          pv_q   <= 1'b1;
        end
      end else begin
        cur_q <= tgt_q;
        if (pv_q) begin
          tgt_q <= pend_q;
          cnt_q <= CNT_LOAD;
          pv_q  <= acc;
          if (acc) pend_q <= req_st;
        end else if (acc) begin
          tgt_q <= req_st;
          cnt_q <= CNT_LOAD;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end else if (acc) begin
      busy_q <= 1'b1;
      tgt_q  <= req_st;
      cnt_q  <= CNT_LOAD;
    end else if (pwr_off_i && (cur_q == PM_D3HOT)) begin
      cur_q <= PM_D3COLD;
    end
  end

  assign state_o     = cur_q;
  assign d0_done_o   = completing && (tgt_q == PM_D0);
  assign cold_exit_o = (cur_q == PM_D3COLD) && !pwr_off_i;

  a_r4_hold_while_counting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (cnt_q != '0)) |=> (cur_q == $past(cur_q)));
  a_r4_land_on_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    completing |=> (cur_q == $past(tgt_q)));
  a_r8_cold_only_from_d3hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cur_q == PM_D3COLD) && ($past(cur_q) != PM_D3COLD)) |-> ($past(cur_q) == PM_D3HOT));
  a_r5_d3hot_leaves_to_d0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(cur_q) == PM_D3HOT) && (cur_q != PM_D3HOT)) |-> (cur_q inside {PM_D0, PM_D3COLD}));
endmodule

// File: rtl/pm_csr_regs.sv
module pm_csr_regs
  import pm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic             event_i,
  input  logic             aux_i,
  input  pm_state_e        state_i,
  input  logic             cold_exit_i,
  output logic             pme_en_o,
  output logic             pme_sts_o,
  output logic [CSR_W-1:0] rdata_o
);
  logic pme_en_q, pme_sts_q, in_cold;

  assign in_cold = (state_i == PM_D3COLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pme_en_q  <= 1'b0;
      pme_sts_q <= 1'b0;
    end else begin
      if (cold_exit_i && !aux_i)  pme_en_q <= 1'b0;
      else if (wr_i && !in_cold)  pme_en_q <= wdata_i[EN_BIT];
      // set wins over a same-cycle clear so no event is lost
      if (event_i && (!in_cold || aux_i))               pme_sts_q <= 1'b1;
      else if (cold_exit_i && !aux_i)                   pme_sts_q <= 1'b0;
      else if (wr_i && !in_cold && wdata_i[STS_BIT])    pme_sts_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!in_cold) begin
      rdata_o[ST_W-1:0] = state_i[ST_W-1:0];
      rdata_o[EN_BIT]   = pme_en_q;
      rdata_o[STS_BIT]  = pme_sts_q;
    end
  end

  assign pme_en_o  = pme_en_q;
  assign pme_sts_o = pme_sts_q;

  a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[STS_BIT] && !event_i && !in_cold) |=> !pme_sts_q);
  a_r7_event_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && !in_cold) |=> pme_sts_q);
endmodule

// File: rtl/pm_signal_gen.sv
module pm_signal_gen
  import pm_pkg::*;
#(
  parameter bit EN_WAKE = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      event_i,
  input  logic      pme_en_i,
  input  logic      pme_sts_i,
  input  pm_state_e state_i,
  input  logic      aux_i,
  input  logic      turnoff_req_i,
  input  logic      d0_done_i,
  input  logic      cold_exit_i,
  output logic      pme_req_o,
  output logic      turnoff_ack_o,
  output logic      wake_n_o
);
  logic blk_q, req_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= 1'b0;
      req_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= turnoff_req_i;
      req_q <= event_i && pme_en_i && (state_i != PM_D3COLD) && !blk_q;
      if (turnoff_req_i)                 blk_q <= 1'b1;
      else if (d0_done_i || cold_exit_i) blk_q <= 1'b0;
    end
  end

  assign pme_req_o     = req_q;
  assign turnoff_ack_o = ack_q;

  generate
    if (EN_WAKE) begin : g_wake
      assign wake_n_o = !((state_i == PM_D3COLD) && aux_i && pme_en_i && pme_sts_i);
    end else begin : g_no_wake
      logic unused_wake;
      assign unused_wake = pme_sts_i ^ aux_i;
      assign wake_n_o    = 1'b1;
    end
  endgenerate

  a_r10_ack_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turnoff_req_i |=> turnoff_ack_o);
  a_r7_req_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pme_req_o |-> ($past(pme_en_i) && ($past(state_i) != PM_D3COLD)));
  a_r9_wake_only_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_n_o |-> (state_i == PM_D3COLD));
endmodule

// File: rtl/pm_func_ctrl.sv
module pm_func_ctrl
  import pm_pkg::*;
#(
  parameter bit EN_PME     = 1'b1,
  parameter bit EN_WAKE    = 1'b0,
  parameter int TRANS_CYC  = 16,
  parameter bit SUP_D1     = 1'b1,
  parameter bit SUP_D2     = 1'b1,
  parameter bit USE_AUX_IN = 1'b1,
  parameter bit AUX_TIE    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [CSR_W-1:0] cfg_wdata_i,
  output logic [CSR_W-1:0] cfg_rdata_o,
  input  logic             pme_event_i,
  input  logic             main_pwr_off_i,
  input  logic             aux_pwr_i,
  input  logic             turnoff_req_i,
  output logic             turnoff_ack_o,
  output logic             pme_req_o,
  output logic             wake_n_o,
  output logic [2:0]       pwr_state_o
);
  logic aux_eff;

  generate
    if (USE_AUX_IN) begin : g_aux_pin
      assign aux_eff = aux_pwr_i;
    end else begin : g_aux_tie
      logic unused_aux;
      assign unused_aux = aux_pwr_i;
      assign aux_eff    = AUX_TIE;
    end
  endgenerate

  generate
    if (EN_PME) begin : g_pm
      pm_state_e st;
      logic      d0_done, cold_exit, pme_en, pme_sts;
      logic      unused_wdata;
      assign unused_wdata = ^{cfg_wdata_i[STS_BIT-1:EN_BIT+1], cfg_wdata_i[EN_BIT-1:ST_W]};

      pm_dstate_ctrl #(
        .TRANS_CYC (TRANS_CYC),
        .SUP_D1    (SUP_D1),
        .SUP_D2    (SUP_D2)
      ) u_dstate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (cfg_wr_i),
        .req_i       (cfg_wdata_i[ST_W-1:0]),
        .pwr_off_i   (main_pwr_off_i),
        .state_o     (st),
        .d0_done_o   (d0_done),
        .cold_exit_o (cold_exit)
      );

      pm_csr_regs u_csr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (cfg_wr_i),
        .wdata_i     (cfg_wdata_i),
        .event_i     (pme_event_i),
        .aux_i       (aux_eff),
        .state_i     (st),
        .cold_exit_i (cold_exit),
        .pme_en_o    (pme_en),
        .pme_sts_o   (pme_sts),
        .rdata_o     (cfg_rdata_o)
      );

      pm_signal_gen #(.EN_WAKE(EN_WAKE)) u_sig (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .event_i       (pme_event_i),
        .pme_en_i      (pme_en),
        .pme_sts_i     (pme_sts),
        .state_i       (st),
        .aux_i         (aux_eff),
        .turnoff_req_i (turnoff_req_i),
        .d0_done_i     (d0_done),
        .cold_exit_i   (cold_exit),
        .pme_req_o     (pme_req_o),
        .turnoff_ack_o (turnoff_ack_o),
        .wake_n_o      (wake_n_o)
      );

      assign pwr_state_o = st;
    end else begin : g_no_pm
      logic ack_q;
      logic unused_pm;
      assign unused_pm = ^{cfg_wr_i, cfg_wdata_i, pme_event_i, main_pwr_off_i, aux_eff};

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ack_q <= 1'b0;
        else         ack_q <= turnoff_req_i;
      end

      assign turnoff_ack_o = ack_q;
      assign cfg_rdata_o   = '0;
      assign pme_req_o     = 1'b0;
      assign wake_n_o      = 1'b1;
      assign pwr_state_o   = PM_D0;

      a_r11_ack_without_pm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        turnoff_req_i |=> turnoff_ack_o);
    end
  endgenerate
endmodule

// File: tb/sim_pm_func_ctrl.sv
module pm_ref_model #(
  parameter bit WAKE    = 1'b1,
  parameter bit AUX_PIN = 1'b1,
  parameter int T       = 16,
  parameter bit D1OK    = 1'b1,
  parameter bit D2OK    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [15:0] wd,
  input  logic        ev,
  input  logic        off,
  input  logic        aux_in,
  input  logic        toff,
  output logic [15:0] rdata,
  output int          st,
  output logic        req,
  output logic        ack,
  output logic        wake_n
);
  int state, tgt, pend, cnt;
  bit busy, pv, en, sts, blk;
  logic aux;

  assign aux = AUX_PIN ? aux_in : 1'b0;

  function automatic bit supported(int r);
    if (r == 1) return D1OK;
    if (r == 2) return D2OK;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int os, otgt, opend, ocnt, eff, r;
    bit ob, opv, oen, oblk, acc, complete, cold_exit, d0_done;
    if (!rst_n) begin
      state = 0; tgt = 0; pend = 0; cnt = 0;
      busy = 0; pv = 0; en = 0; sts = 0; blk = 0;
      req <= 0; ack <= 0;
    end else begin
      os = state; otgt = tgt; opend = pend; ocnt = cnt;
      ob = busy; opv = pv; oen = en; oblk = blk;
      eff = opv ? opend : (ob ? otgt : os);
      r = int'(wd[1:0]);
      acc = wr && os != 4 && r != eff && supported(r) && !(eff == 3 && r != 0);
      complete = ob && ocnt == 0;
      cold_exit = (os == 4) && !off;
      d0_done = complete && otgt == 0;
      ack <= toff;
      req <= ev && oen && os != 4 && !oblk;
      if (os == 4) begin
        if (!off) state = 0;
      end else if (ob) begin
        if (!complete) begin
          cnt = ocnt - 1;
          if (acc) begin pend = r; pv = 1; end
        end else begin
          state = otgt;
          if (opv) begin
            tgt = opend; cnt = T - 1; pv = acc;
            if (acc) pend = r;
          end else if (acc) begin
            tgt = r; cnt = T - 1;
          end else busy = 0;
        end
      end else if (acc) begin
        busy = 1; tgt = r; cnt = T - 1;
      end else if (off && os == 3) state = 4;
      if (toff) blk = 1;
      else if (cold_exit || d0_done) blk = 0;
      if (cold_exit && !aux) en = 0;
      else if (wr && os != 4) en = wd[8];
      if (ev && (os != 4 || aux)) sts = 1;
      else if (cold_exit && !aux) sts = 0;
      else if (wr && os != 4 && wd[15]) sts = 0;
    end
  end

  always_comb begin
    rdata = (state == 4) ? 16'h0 : {sts, 6'b0, en, 6'b0, state[1:0]};
    st = state;
    wake_n = !(WAKE && state == 4 && aux && en && sts);
  end
endmodule

module sim_pm_func_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic ev = 1'b0, off = 1'b0, aux = 1'b1, toff = 1'b0;

  logic [15:0] rd0, rd1, rd2;
  logic ack0, ack1, ack2, req0, req1, req2, wk0, wk1, wk2;
  logic [2:0] st0, st1, st2;

  logic [15:0] m0_rd, m1_rd;
  int m0_st, m1_st;
  logic m0_req, m1_req, m0_ack, m1_ack, m0_wk, m1_wk;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pm_func_ctrl #(.EN_PME(1'b1), .EN_WAKE(1'b1), .TRANS_CYC(16), .SUP_D2(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rd0),
    .pme_event_i(ev), .main_pwr_off_i(off), .aux_pwr_i(aux), .turnoff_req_i(toff),
    .turnoff_ack_o(ack0), .pme_req_o(req0), .wake_n_o(wk0), .pwr_state_o(st0));

  pm_func_ctrl #(.TRANS_CYC(16), .SUP_D2(1'b0), .USE_AUX_IN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rd1),
    .pme_event_i(ev), .main_pwr_off_i(off), .aux_pwr_i(aux), .turnoff_req_i(toff),
    .turnoff_ack_o(ack1), .pme_req_o(req1), .wake_n_o(wk1), .pwr_state_o(st1));

  pm_func_ctrl #(.EN_PME(1'b0)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rd2),
    .pme_event_i(ev), .main_pwr_off_i(off), .aux_pwr_i(aux), .turnoff_req_i(toff),
    .turnoff_ack_o(ack2), .pme_req_o(req2), .wake_n_o(wk2), .pwr_state_o(st2));

  pm_ref_model #(.WAKE(1'b1), .AUX_PIN(1'b1)) m0 (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wd(cfg_wdata), .ev(ev), .off(off), .aux_in(aux),
    .toff(toff), .rdata(m0_rd), .st(m0_st), .req(m0_req), .ack(m0_ack), .wake_n(m0_wk));

  pm_ref_model #(.WAKE(1'b0), .AUX_PIN(1'b0)) m1 (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wd(cfg_wdata), .ev(ev), .off(off), .aux_in(aux),
    .toff(toff), .rdata(m1_rd), .st(m1_st), .req(m1_req), .ack(m1_ack), .wake_n(m1_wk));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 u0 rdata vs model", 32'(rd0), 32'(m0_rd));
      chk("R4 u0 state vs model", 32'(st0), 32'(m0_st));
      chk("R7 u0 pme_req vs model", 32'(req0), 32'(m0_req));
      chk("R10 u0 ack vs model", 32'(ack0), 32'(m0_ack));
      chk("R9 u0 wake_n vs model", 32'(wk0), 32'(m0_wk));
      chk("R12 u1 rdata vs model", 32'(rd1), 32'(m1_rd));
      chk("R12 u1 state vs model", 32'(st1), 32'(m1_st));
      chk("R12 u1 pme_req vs model", 32'(req1), 32'(m1_req));
      chk("R9 u1 wake_n stays high", 32'(wk1), 32'(m1_wk));
      chk("R11 u2 inert", {rd2, 13'(st2), req2, wk2, ack2}, {16'h0, 13'h0, 1'b0, 1'b1, m0_ack});
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic cfg_write(logic [15:0] d);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_event();
    ev = 1'b1;
    step();
    ev = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    chk("R1 rdata", 32'(rd0), 32'h0);
    chk("R1 state", 32'(st0), 32'd0);
    chk("R1 wake_n", 32'(wk0), 32'd1);
    chk("R1 req/ack", {req0, ack0}, 2'b00);

    cfg_write(16'h0100);
    chk("R2 enable in bit 8", 32'(rd0), 32'h0100);
    pulse_event();
    chk("R7 req pulses when enabled", 32'(req0), 32'd1);
    chk("R2 status in bit 15", 32'(rd0), 32'h8100);
    step();
    chk("R7 req is one cycle", 32'(req0), 32'd0);

    cfg_write(16'h0100);
    chk("R3 write 0 keeps status", 32'(rd0), 32'h8100);
    cfg_write(16'h8100);
    chk("R3 write 1 clears status", 32'(rd0), 32'h0100);

    cfg_write(16'h0000);
    pulse_event();
    chk("R7 no req when disabled", 32'(req0), 32'd0);
    chk("R7 status set while disabled", 32'(rd0), 32'h8000);
    cfg_write(16'h8000);

    cfg_write(16'h0001);
    step(15);
    chk("R4 state held before timer end", 32'(st0), 32'd0);
    step();
    chk("R4 state changes at timer end", 32'(st0), 32'd1);
    chk("R2 state in bits 1:0", 32'(rd0), 32'h0001);

    cfg_write(16'h0002);
    step(20);
    chk("R5 unsupported D2 ignored", 32'(st0), 32'd1);

    cfg_write(16'h0003);
    cfg_write(16'h0000);
    step(14);
    chk("R6 first target not yet", 32'(st0), 32'd1);
    step();
    chk("R6 first target reached", 32'(st0), 32'd3);
    step(15);
    chk("R6 held request still waiting", 32'(st0), 32'd3);
    step();
    chk("R6 held request completes", 32'(st0), 32'd0);

    cfg_write(16'h0103);
    step(16);
    chk("R4 D3hot reached", 32'(rd0), 32'h0103);
    cfg_write(16'h0101);
    step(20);
    chk("R5 D3hot to D1 ignored", 32'(st0), 32'd3);

    toff = 1'b1;
    step();
    toff = 1'b0;
    chk("R10 ack next cycle", 32'(ack0), 32'd1);
    step();
    chk("R10 ack is one cycle", 32'(ack0), 32'd0);
    pulse_event();
    chk("R10 req blocked after turn-off", 32'(req0), 32'd0);
    cfg_write(16'h8103);
    chk("R3 clear in D3hot", 32'(rd0), 32'h0103);

    off = 1'b1;
    step();
    chk("R8 D3cold entered", 32'(st0), 32'd4);
    chk("R2 reads zero in D3cold", 32'(rd0), 32'h0);
    chk("R9 wake high with status clear", 32'(wk0), 32'd1);
    cfg_write(16'h0000);
    pulse_event();
    chk("R9 wake low in D3cold", 32'(wk0), 32'd0);
    chk("R7 no req in D3cold", 32'(req0), 32'd0);
    chk("R9 wake high when not built in", 32'(wk1), 32'd1);
    off = 1'b0;
    step();
    chk("R8 back to D0", 32'(st0), 32'd0);
    chk("R8 sticky bits kept with aux", 32'(rd0), 32'h8100);
    chk("R9 wake high after D3cold", 32'(wk0), 32'd1);
    chk("R12 tied aux clears sticky bits", 32'(rd1), 32'h0000);
    pulse_event();
    chk("R10 block lifted after D3cold exit", 32'(req0), 32'd1);

    cfg_write(16'h8103);
    step(16);
    aux = 1'b0;
    off = 1'b1;
    step();
    pulse_event();
    chk("R9 no wake without aux", 32'(wk0), 32'd1);
    off = 1'b0;
    step();
    chk("R8 no aux: bits cleared, event ignored", 32'(rd0), 32'h0000);
    aux = 1'b1;

    cfg_write(16'h0001);
    cfg_write(16'h0003);
    cfg_write(16'h0000);
    step(14);
    chk("R6 first of queued writes", 32'(st0), 32'd1);
    step(16);
    chk("R6 latest held write wins", 32'(st0), 32'd0);

    toff = 1'b1;
    step();
    toff = 1'b0;
    chk("R11 ack without PME handling", 32'(ack2), 32'd1);
    step(4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule